// File: doc/BRIEF.md
# Block-Ownership Write Guard

This block sits on the data-memory write path of a small processor. The data address space is cut into equal blocks of 16 addresses, and a 16-entry table records which software module owns each block. A register holds the ID of the module that is running now. On every write strobe from the CPU, the guard looks up the owner of the addressed block. It passes the strobe on to memory only if that owner is the running module, or if the running module is the trusted kernel (ID 0).

A write that is refused never reaches memory. In the next cycle the guard raises a single-cycle fault pulse and captures the offending address. Reads never pass through this block: the read path and the address bus go straight to memory. Only the kernel can change the owner table and the running-module register, through a configuration port. A kernel-entry input, driven by the trap or interrupt path, returns control to the kernel.

Top module: `mem_write_guard`

## Requirements
- R1: After reset, `active_id` is 0, `fault` is 0, `fault_addr` is 0 and every block's owner is 0.
- R2: While `active_id` is 0, every write strobe is forwarded to `mem_wr` in the same cycle and never causes a fault.
- R3: While `active_id` is nonzero, a write to a block whose owner equals `active_id` is forwarded to `mem_wr` in the same cycle, without a fault.
- R4: While `active_id` is nonzero, a write to a block whose owner differs from it leaves `mem_wr` low in that cycle. `fault` is then high for exactly the following cycle, and back-to-back refused writes give back-to-back fault cycles.
- R5: `fault_addr` takes the address of a refused write in the cycle `fault` rises, and it holds its value in all other cycles.
- R6: The block index is `cpu_addr[7:4]`. Addresses 16·k through 16·k+15 share owner entry k, and the two sides of a block boundary are judged by different entries.
- R7: With `cfg_we` high and `active_id` at 0: `cfg_sel`=0 writes `cfg_data` into owner entry `cfg_idx`, and `cfg_sel`=1 writes `cfg_data` into `active_id`. The change takes effect from the next cycle.
- R8: A configuration write made while `active_id` is nonzero has no effect on the owner table or on `active_id`.
- R9: `kernel_entry` high sets `active_id` to 0 in the next cycle, even if a configuration write to `active_id` is offered in the same cycle.
- R10: With `cpu_wr` low, `mem_wr` stays low and no fault is raised, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 8 | CPU data address |
| cpu_wr | input | 1 | CPU write strobe |
| mem_wr | output | 1 | Write strobe passed on to data memory |
| fault | output | 1 | One-cycle pulse that follows a refused write |
| fault_addr | output | 8 | Address of the most recent refused write |
| active_id | output | 3 | ID of the running module (0 = kernel) |
| kernel_entry | input | 1 | Forces the running module back to the kernel |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 = owner entry, 1 = running-module register |
| cfg_idx | input | 4 | Owner entry index |
| cfg_data | input | 3 | Value to write |

## Verification
A corrupted owner entry shows up as a wrong `mem_wr` level, in the same cycle, on the first write that a non-kernel module makes to that block. A lost or wrong update of the running-module register shows on `active_id` one cycle later, and on every write decision after that. Because all owner entries reset to the kernel, a table entry that a configuration write fails to reach keeps refusing the intended owner. Checking `mem_wr`, `fault`, `fault_addr` and `active_id` on every cycle against an independent model therefore catches a bad state within one cycle of the first access that depends on it.

// File: rtl/mem_write_guard.sv
module mem_write_guard #(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 4,
  parameter int ID_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_wr,
  output logic                    mem_wr,
  output logic                    fault,
  output logic [ADDR_W-1:0]       fault_addr,
  output logic [ID_W-1:0]         active_id,
  input  logic                    kernel_entry,
  input  logic                    cfg_we,
  input  logic                    cfg_sel,
  input  logic [ADDR_W-BLK_W-1:0] cfg_idx,
  input  logic [ID_W-1:0]         cfg_data
);

  localparam int IDX_W = ADDR_W - BLK_W;
  localparam int NBLK  = 1 << IDX_W;

  logic [ID_W-1:0] owner [NBLK];

  wire [IDX_W-1:0] blk     = cpu_addr[ADDR_W-1:BLK_W];
  wire             kernel  = (active_id == '0);
  wire             allowed = kernel || (owner[blk] == active_id);
  wire             blocked = cpu_wr && !allowed;
  wire             cfg_ok  = cfg_we && kernel;

  assign mem_wr = cpu_wr && allowed;

  for (genvar g = 0; g < NBLK; g++) begin : g_owner
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        owner[g] <= '0;
      else if (cfg_ok && !cfg_sel && cfg_idx == IDX_W'(g))
        owner[g] <= cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      active_id <= '0;
    else if (kernel_entry)
      active_id <= '0;
    else if (cfg_ok && cfg_sel)
      active_id <= cfg_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fault      <= 1'b0;
      fault_addr <= '0;
    end else begin
      fault <= blocked;
      if (blocked) fault_addr <= cpu_addr;
    end

  assert_no_write_without_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> cpu_wr);

  assert_kernel_always_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && active_id == '0) |-> mem_wr);

  assert_fault_follows_refusal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($past(cpu_wr) && !$past(mem_wr) && $past(active_id) != '0));

  assert_fault_addr_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_addr == $past(cpu_addr));

  assert_fault_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> $stable(fault_addr) || $fell(fault) == 1'b0 && $past(fault));

  assert_locked_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_id != '0 && !kernel_entry) |=> $stable(active_id));

  assert_kernel_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_entry |=> active_id == '0);

endmodule

// File: tb/test_mem_write_guard.sv
module test_mem_write_guard;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0;
  logic       mem_wr;
  logic       fault;
  logic [7:0] fault_addr;
  logic [2:0] active_id;
  logic       kernel_entry = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [2:0] cfg_data = '0;

  mem_write_guard i_mem_write_guard (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .mem_wr(mem_wr),
    .fault(fault), .fault_addr(fault_addr), .active_id(active_id),
    .kernel_entry(kernel_entry), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int m_owner [16];
  int m_active;
  int m_fault;
  int m_faddr;

  function automatic bit m_allowed(int addr);
    return (m_active == 0) || (m_owner[addr / 16] == m_active);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_owner[i]) m_owner[i] = 0;
      m_active = 0; m_fault = 0; m_faddr = 0;
    end else begin
      bit blk;
      int old_active;
      blk = cpu_wr && !m_allowed(int'(cpu_addr));
      old_active = m_active;
      m_fault = blk;
      if (blk) m_faddr = int'(cpu_addr);
      if (cfg_we && old_active == 0 && !cfg_sel) m_owner[cfg_idx] = int'(cfg_data);
      if (kernel_entry) m_active = 0;
      else if (cfg_we && old_active == 0 && cfg_sel) m_active = int'(cfg_data);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    chk("R4 fault", int'(fault), m_fault);
    chk("R5 fault_addr", int'(fault_addr), m_faddr);
    chk("R7 active_id", int'(active_id), m_active);
  endtask

  task automatic check_wr();
    string tag;
    if (!cpu_wr) tag = "R10 mem_wr";
    else if (m_active == 0) tag = "R2 mem_wr";
    else if (m_allowed(int'(cpu_addr))) tag = "R3 mem_wr";
    else tag = "R4 mem_wr";
    chk(tag, int'(mem_wr), int'(cpu_wr && m_allowed(int'(cpu_addr))));
  endtask

  task automatic step(int addr, bit wr, bit ke = 0, bit cwe = 0, bit csel = 0,
                      int cidx = 0, int cdat = 0);
    @(negedge clk);
    check_regs();
    cpu_addr = 8'(addr); cpu_wr = wr; kernel_entry = ke;
    cfg_we = cwe; cfg_sel = csel; cfg_idx = 4'(cidx); cfg_data = 3'(cdat);
    #1;
    check_wr();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 active_id", int'(active_id), 0);
    chk("R1 fault", int'(fault), 0);
    chk("R1 fault_addr", int'(fault_addr), 0);
    chk("R1 mem_wr", int'(mem_wr), 0);
    rst_n = 1'b1;

    for (int a = 0; a < 256; a += 37) step(a, 1);
    step(8'hFF, 1);

    step(0, 0, 0, 1, 1, 0, 2);
    for (int b = 0; b < 16; b++) step(b * 16 + 1, 1);
    step(0, 0, 1);

    for (int b = 0; b < 16; b++) step(0, 0, 0, 1, 0, b, b % 8);
    step(0, 0, 0, 1, 1, 0, 3);
    step(8'h30, 1);
    step(8'h3F, 1);
    step(8'h2F, 1);
    step(8'h40, 1);
    step(8'hB5, 1);
    step(8'h77, 0);
    step(8'h38, 1);
    @(negedge clk);
    chk("R6 block 3 boundary pass", int'(fault), 0);

    step(0, 0, 0, 1, 0, 2, 3);
    step(0, 0, 0, 1, 1, 0, 5);
    step(8'h20, 1);
    @(negedge clk);
    chk("R8 owner entry unchanged", int'(fault), 1);
    chk("R8 active unchanged", int'(active_id), 3);

    step(0, 0, 1, 1, 1, 0, 6);
    @(negedge clk);
    chk("R9 kernel entry wins", int'(active_id), 0);

    for (int n = 0; n < 2000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4)       step(0, 0, 1);
      else if (r < 10) step(0, 0, 0, 1, 1, 0, int'($urandom_range(0, 7)));
      else if (r < 16) step(0, 0, 0, 1, 0, int'($urandom_range(0, 15)), int'($urandom_range(0, 7)));
      else             step(int'($urandom_range(0, 255)), r < 80);
    end
    step(0, 0);
    @(negedge clk);
    check_regs();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule